// File: doc/BRIEF.md
# Multiplexed External Memory Bus Master

This block turns single-word requests from inside the chip into cycles on a classic 8-bit external memory bus. A request is one of three kinds: an instruction fetch from code space, a data read, or a data write. Data requests carry either a full 16-bit address or a short 8-bit one. The upper address byte goes out on its own port. The lower address byte and the data byte take turns on one shared byte port. The block also drives an address-latch strobe, which an external transparent latch uses to hold the low byte, and three active-low strobes: one for code fetch, one for data read and one for data write.

Every bus cycle passes through four timed phases, and each phase lasts a parameterised number of clocks. In the first phase the latch strobe is high and the address is presented. In the second the latch strobe is low and the address is still held. In the third the selected strobe is low and data moves. In the fourth, the recovery phase, all strobes are high again. Read data is taken from the shared port on the clock where the strobe returns high. A one-cycle completion pulse then marks the end of the access. The requester may only start a new access while the ready output is high.

Top module: `xbus_master`

## Requirements
- R1: While reset is active, and after it, with no request: latch strobe low, all three active-low strobes high, shared port not driven, ready high, done low, upper address port 0.
- R2: After a request is accepted, the latch strobe stays high for ALE_HI_CYC clocks. During those clocks the shared port is driven with the low address byte.
- R3: The latch strobe is then low for ALE_LO_CYC clocks. The shared port still drives the low address byte, and no strobe goes low before this phase has ended.
- R4: For STROBE_CYC clocks one strobe is low: code-fetch strobe for kind 2'b00, read strobe for kind 2'b01, write strobe for kind 2'b10. At no time is more than one strobe low, and no strobe is low outside this phase.
- R5: On code fetches and data reads the shared port is released during the strobe phase. The byte on the shared input at the last strobe-low clock appears on rdata from the next clock, and done is high for exactly that one clock (the first recovery clock). Writes pulse done at the same point and leave rdata unchanged.
- R6: On a data write the shared port drives the write byte for the whole strobe phase.
- R7: The upper address port does not change while an access is in progress. A data access with the short-address flag set leaves it at its previous value. Code fetches ignore the flag and always drive the upper byte.
- R8: A request is taken only when ready is high. Requests presented while busy are ignored, and kind 2'b11 is never accepted. Ready goes low on the clock after acceptance and returns high after the RECOVER_CYC recovery clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 code fetch, 01 data read, 10 data write, 11 reserved |
| req_short | input | 1 | Data access uses only the low 8 address bits |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read or fetch |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input value |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The embedded assertions assume that the phase lengths are at least one clock each and that reset is held for at least one clock edge before any request. The property on the rdata capture also assumes that ad_in is a clean level at the capturing edge. The stimulus keeps to these rules: reset lasts several cycles, and requests change only on the falling clock edge. The bench models an external memory whose read byte is a fixed function of the address latched by the strobe and of the access kind. This means the capture path and the external latch path are both checked against what the bench itself computes.

// File: rtl/xbus_pkg.sv
// Shared types of the external bus master.
// Assumes: request kind encoding is fixed by the request interface.
package xbus_pkg;
    typedef enum logic [1:0] {
        KIND_CODE = 2'b00,
        KIND_DRD  = 2'b01,
        KIND_DWR  = 2'b10,
        KIND_RSVD = 2'b11
    } xbus_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ALE_HI  = 3'd1,
        PH_ALE_LO  = 3'd2,
        PH_STROBE  = 3'd3,
        PH_RECOVER = 3'd4
    } xbus_phase_e;
endpackage

// File: rtl/xbus_phase_seq.sv
// Phase sequencer: steps IDLE -> ALE_HI -> ALE_LO -> STROBE -> RECOVER -> IDLE,
// each active phase lasting its parameterised number of clocks.
// Assumes: every phase length is at least 1; start is only honoured in IDLE.
module xbus_phase_seq
    import xbus_pkg::*;
#(
    parameter int ALE_HI_CYC  = 2,
    parameter int ALE_LO_CYC  = 1,
    parameter int STROBE_CYC  = 3,
    parameter int RECOVER_CYC = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output xbus_phase_e phase,
    output logic        last_beat,
    output logic        done
);
    localparam int MAX_AB  = (ALE_HI_CYC > ALE_LO_CYC) ? ALE_HI_CYC : ALE_LO_CYC;
    localparam int MAX_CD  = (STROBE_CYC > RECOVER_CYC) ? STROBE_CYC : RECOVER_CYC;
    localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_m1;
    xbus_phase_e      phase_nx;

    // Terminal count of the current phase.
    always_comb begin
        case (phase)
            PH_ALE_HI:  len_m1 = CNT_W'(ALE_HI_CYC - 1);
            PH_ALE_LO:  len_m1 = CNT_W'(ALE_LO_CYC - 1);
            PH_STROBE:  len_m1 = CNT_W'(STROBE_CYC - 1);
            PH_RECOVER: len_m1 = CNT_W'(RECOVER_CYC - 1);
            default:    len_m1 = '0;
        endcase
    end

    // Successor of each active phase.
    always_comb begin
        case (phase)
            PH_ALE_HI:  phase_nx = PH_ALE_LO;
            PH_ALE_LO:  phase_nx = PH_STROBE;
            PH_STROBE:  phase_nx = PH_RECOVER;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    assign last_beat = (phase != PH_IDLE) && (cnt == len_m1);

    // Phase and beat counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (start) phase <= PH_ALE_HI;
        end else if (last_beat) begin
            phase <= phase_nx;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Completion pulse on the first recovery clock.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (phase == PH_STROBE) && last_beat;
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !last_beat) |=> (phase == $past(phase)));
endmodule

// File: rtl/xbus_req_latch.sv
// Request holding register: keeps kind, low address byte and write byte for
// the whole access, and owns the upper address byte driven on its port.
// Assumes: accept is only raised when the sequencer is idle.
module xbus_req_latch
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  xbus_kind_e        kind_in,
    input  logic              short_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output xbus_kind_e        kind_q,
    output logic [DATA_W-1:0] addr_lo_q,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_q,
    output logic [DATA_W-1:0] wdata_q
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic upd_hi;
    assign upd_hi = (kind_in == KIND_CODE) || !short_in;

    // Capture the per-access fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= KIND_CODE;
            addr_lo_q <= '0;
            wdata_q   <= '0;
        end else if (accept) begin
            kind_q    <= kind_in;
            addr_lo_q <= addr_in[DATA_W-1:0];
            wdata_q   <= wdata_in;
        end
    end

    // Upper byte follows full-address accesses only.
    always_ff @(posedge clk) begin
        if (!rst_n)                 addr_hi_q <= '0;
        else if (accept && upd_hi)  addr_hi_q <= addr_in[ADDR_W-1 -: HI_W];
    end
endmodule

// File: rtl/xbus_pin_drive.sv
// Pin decoder: maps the current phase and request kind onto the latch strobe,
// the three active-low strobes and the shared port; captures read data.
// Assumes: phase comes from registers, so the pins change only after a clock.
module xbus_pin_drive
    import xbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xbus_phase_e       phase,
    input  logic              last_beat,
    input  xbus_kind_e        kind,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] rdata
);
    logic in_strobe;
    logic addr_phase;
    logic any_low;

    assign in_strobe  = (phase == PH_STROBE);
    assign addr_phase = (phase == PH_ALE_HI) || (phase == PH_ALE_LO);

    // Strobe and shared-port decode.
    always_comb begin
        ale    = (phase == PH_ALE_HI);
        psen_n = !(in_strobe && kind == KIND_CODE);
        rd_n   = !(in_strobe && kind == KIND_DRD);
        wr_n   = !(in_strobe && kind == KIND_DWR);
        ad_oe  = addr_phase || (in_strobe && kind == KIND_DWR);
        ad_out = addr_phase ? addr_lo : wdata;
    end

    // Sample the shared port on the clock where the read strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          rdata <= '0;
        else if (in_strobe && last_beat && kind != KIND_DWR) rdata <= ad_in;
    end

    assign any_low = !psen_n || !rd_n || !wr_n;

    // R4
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({psen_n, rd_n, wr_n}) >= 2);

    // R3
    strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_low) |-> (!ale && !$past(ale)));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !psen_n) |-> !ad_oe);

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && last_beat && kind != KIND_DWR) |=> (rdata == $past(ad_in)));

    // R2
    ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && !any_low));
endmodule

// File: rtl/xbus_master.sv
// External memory bus master top: accepts one request at a time and runs a
// four-phase multiplexed address/data cycle on the external pins.
// Assumes: requester holds request fields stable while req_valid is high.
module xbus_master
    import xbus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int ALE_HI_CYC  = 2,
    parameter int ALE_LO_CYC  = 1,
    parameter int STROBE_CYC  = 3,
    parameter int RECOVER_CYC = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic                     req_short,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n
);
    xbus_phase_e       phase;
    logic              last_beat;
    logic              accept;
    xbus_kind_e        kind_in;
    xbus_kind_e        kind_q;
    logic [DATA_W-1:0] addr_lo_q;
    logic [DATA_W-1:0] wdata_q;

    assign kind_in   = xbus_kind_e'(req_kind);
    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready && (kind_in != KIND_RSVD);

    xbus_phase_seq #(
        .ALE_HI_CYC (ALE_HI_CYC),
        .ALE_LO_CYC (ALE_LO_CYC),
        .STROBE_CYC (STROBE_CYC),
        .RECOVER_CYC(RECOVER_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .phase    (phase),
        .last_beat(last_beat),
        .done     (done)
    );

    xbus_req_latch #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .kind_in  (kind_in),
        .short_in (req_short),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .kind_q   (kind_q),
        .addr_lo_q(addr_lo_q),
        .addr_hi_q(addr_hi),
        .wdata_q  (wdata_q)
    );

    xbus_pin_drive #(
        .DATA_W(DATA_W)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .last_beat(last_beat),
        .kind     (kind_q),
        .addr_lo  (addr_lo_q),
        .wdata    (wdata_q),
        .ad_in    (ad_in),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .rdata    (rdata)
    );

    // R7
    addr_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(addr_hi));

    // R7
    short_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_short && kind_in != KIND_CODE) |=> $stable(addr_hi));

    // R8
    take_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (phase != PH_ALE_HI || $past(phase) == PH_ALE_HI));
endmodule

// File: tb/xbus_master_test.sv
// Bench: a behavioural model steps through each access by clock count and
// is compared with every output on every falling clock edge.
module xbus_master_test;
    localparam int PERIOD = 10;
    localparam int N1 = 2;
    localparam int N2 = 2;
    localparam int N3 = 3;
    localparam int N4 = 2;
    localparam int TOTAL = N1 + N2 + N3 + N4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_short = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready, done, ad_oe, ale, psen_n, rd_n, wr_n;
    logic [7:0]  rdata, addr_hi, ad_out, ad_in;

    int n_run = 0;
    int n_fail = 0;
    bit started = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    xbus_master #(
        .ALE_HI_CYC(N1), .ALE_LO_CYC(N2), .STROBE_CYC(N3), .RECOVER_CYC(N4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_short(req_short), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .addr_hi(addr_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    // External memory: a byte per address, different for code and data space.
    function automatic logic [7:0] mem_byte(input logic [1:0] k, input logic [15:0] a);
        if (k == 2'b00) return a[7:0] ^ a[15:8] ^ 8'hC3;
        return a[7:0] + a[15:8] + 8'h11;
    endfunction

    logic [7:0] ext_lo;
    always_latch if (ale) ext_lo = ad_out;

    always_comb begin
        if (!psen_n)    ad_in = mem_byte(2'b00, {addr_hi, ext_lo});
        else if (!rd_n) ad_in = mem_byte(2'b01, {addr_hi, ext_lo});
        else            ad_in = 8'hEE;
    end

    logic [15:0] wr_seen_addr;
    logic [7:0]  wr_seen_data;

    // Reference model state.
    bit         m_busy = 1'b0;
    int         m_t = 0;
    logic [1:0] m_kind = 2'b00;
    logic [7:0] m_lo = 8'h0, m_hi = 8'h0, m_wd = 8'h0, m_rdata = 8'h0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_busy = 1'b0; m_t = 0; m_hi = 8'h0; m_rdata = 8'h0;
        end else if (m_busy) begin
            if (m_t == N1 + N2 + N3 - 1 && m_kind != 2'b10)
                m_rdata = mem_byte(m_kind, {m_hi, m_lo});
            if (m_t == TOTAL - 1) m_busy = 1'b0;
            else m_t++;
        end else if (req_valid && req_kind != 2'b11) begin
            m_busy = 1'b1; m_t = 0; m_kind = req_kind;
            m_lo = req_addr[7:0]; m_wd = req_wdata;
            if (req_kind == 2'b00 || !req_short) m_hi = req_addr[15:8];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            bit e_ale, e_ps, e_rd, e_wr, e_oe, e_done;
            logic [7:0] e_ad;
            string ad_tag;
            bit in_st;
            in_st  = m_busy && m_t >= N1 + N2 && m_t < N1 + N2 + N3;
            e_ale  = m_busy && m_t < N1;
            e_ps   = !(in_st && m_kind == 2'b00);
            e_rd   = !(in_st && m_kind == 2'b01);
            e_wr   = !(in_st && m_kind == 2'b10);
            e_oe   = (m_busy && m_t < N1 + N2) || (in_st && m_kind == 2'b10);
            e_ad   = (m_busy && m_t < N1 + N2) ? m_lo : m_wd;
            e_done = m_busy && m_t == N1 + N2 + N3;
            ad_tag = !m_busy ? "R1" : (m_t < N1) ? "R2" : (m_t < N1 + N2) ? "R3" : "R6";
            chk(ale == e_ale, "R2 ale", 16'(ale), 16'(e_ale));
            chk(psen_n == e_ps, "R4 psen_n", 16'(psen_n), 16'(e_ps));
            chk(rd_n == e_rd, "R4 rd_n", 16'(rd_n), 16'(e_rd));
            chk(wr_n == e_wr, "R4 wr_n", 16'(wr_n), 16'(e_wr));
            chk(ad_oe == e_oe, {ad_tag, " ad_oe (R5 release)"}, 16'(ad_oe), 16'(e_oe));
            if (e_oe) chk(ad_out == e_ad, {ad_tag, " ad_out"}, 16'(ad_out), 16'(e_ad));
            chk(done == e_done, "R5 done", 16'(done), 16'(e_done));
            chk(rdata == m_rdata, "R5 rdata", 16'(rdata), 16'(m_rdata));
            chk(addr_hi == m_hi, "R7 addr_hi", 16'(addr_hi), 16'(m_hi));
            chk(req_ready == !m_busy, "R8 ready", 16'(req_ready), 16'(!m_busy));
            if (!wr_n) begin
                wr_seen_addr = {addr_hi, ext_lo};
                wr_seen_data = ad_out;
            end
            if (e_done && m_kind == 2'b10) begin
                chk(wr_seen_addr == {m_hi, m_lo}, "R6 write addr", wr_seen_addr, {m_hi, m_lo});
                chk(wr_seen_data == m_wd, "R6 write data", 16'(wr_seen_data), 16'(m_wd));
            end
        end
    end

    task automatic issue(input logic [1:0] k, input bit s, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_short = s; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(PERIOD * 50000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(ale == 1'b0 && psen_n && rd_n && wr_n && !ad_oe, "R1 strobes in reset",
            16'({ale, psen_n, rd_n, wr_n, ad_oe}), 16'b01110);
        chk(req_ready && !done && addr_hi == 8'h0, "R1 ready/done/addr_hi in reset",
            16'({req_ready, done, addr_hi}), 16'h200);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        issue(2'b00, 1'b0, 16'h1234, 8'h00);   // code fetch
        issue(2'b01, 1'b0, 16'hA5F0, 8'h00);   // data read, full address
        issue(2'b10, 1'b0, 16'h0F0F, 8'h3C);   // data write, full address
        issue(2'b01, 1'b1, 16'hFF77, 8'h00);   // R7 short read keeps upper byte
        issue(2'b10, 1'b1, 16'h9910, 8'hA5);   // R7 short write keeps upper byte
        issue(2'b00, 1'b1, 16'hBEEF, 8'h00);   // R7 code fetch ignores short flag
        // R8 requests during a busy access are ignored
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b01; req_short = 1'b0; req_addr = 16'h4242;
        @(negedge clk);
        req_kind = 2'b10; req_addr = 16'h7777; req_wdata = 8'h55;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        // R8 reserved kind never starts an access
        req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'hDEAD;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        // back-to-back accesses with varied patterns
        for (int i = 0; i < 12; i++) begin
            logic [15:0] a;
            a = 16'(i * 16'h1357 + 16'h0101);
            issue(2'(i % 3), 1'(i % 4 == 1), a, 8'(i * 29));
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule